// File: doc/BRIEF.md
# Flat Page-Table Address Translator

The translator maps a 32-bit I/O virtual address to a physical address through a single-level table kept in memory. The table holds one 32-bit descriptor for every 4 KB page of the 4 GB space, which makes 2^20 entries and 4 MB in total. A client presents a virtual address and a client ID on a valid/ready handshake. The block first looks in a small fully associative cache of recent good translations. On a hit it answers on the next cycle. On a miss it reads the descriptor at the table base plus four times the page number, then answers once the read data has come back.

A descriptor has its page frame in bits [31:12] and its flags in the low bits. Bit 1 says the entry is valid, and bit 3 says the page is non-secure. If the fetched descriptor is not valid, the access is sent to a protection address aligned to 128 bytes. At the same time a one-cycle fault pulse carries the faulting virtual address and client ID to a separate reporting block. Only one table read is ever outstanding. Invalidation of the cache belongs to another block.

Top module: `flat_xlate`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, mem_req and flt_valid are all 0.
- R2: On a cache miss, mem_req pulses for exactly one cycle, in the cycle after acceptance. mem_addr is tbl_base + {va[31:12], 2'b00}, taken modulo 2^32.
- R3: When the fetched descriptor has bit 1 set, rsp_pa is {desc[31:12], va[11:0]} and rsp_fault is 0. The response appears one cycle after mem_rvalid.
- R4: rsp_nonsec reports descriptor bit 3 for valid translations. It is 0 on a fault.
- R5: When the fetched descriptor has bit 1 clear, rsp_fault is 1 and rsp_pa is {prot_addr[31:7], 7'b0}. In the same cycle, flt_valid pulses with flt_va and flt_id equal to the request.
- R6: req_ready is 0 from a miss's acceptance until its response, so at most one table read is outstanding. mem_rvalid arriving while no read is pending produces no response.
- R7: A request whose page is cached gets its response in the next cycle, with no memory read. The response comes from the cached translation even if the table has since changed.
- R8: Faulting descriptors are never cached, so repeating a faulting request reads the table again.
- R9: New valid translations fill the cache ways in round-robin order. The (WAYS+1)-th distinct page evicts the first one filled.
- R10: rsp_id echoes the client ID of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_base | input | 32 | Byte address of the translation table |
| prot_addr | input | 32 | Protection redirect address (low 7 bits ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_va | input | 32 | Virtual address |
| req_id | input | ID_W | Client ID |
| rsp_valid | output | 1 | Response valid (one cycle) |
| rsp_pa | output | 32 | Physical or redirect address |
| rsp_fault | output | 1 | Translation fault |
| rsp_nonsec | output | 1 | Page is non-secure |
| rsp_id | output | ID_W | Client ID of the response |
| mem_req | output | 1 | Table read request (one-cycle pulse) |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor |
| flt_valid | output | 1 | Fault pulse |
| flt_va | output | 32 | Faulting virtual address |
| flt_id | output | ID_W | Faulting client ID |

## Verification
The bench rewrites the table after a page has been cached and expects the old translation to come back. A design that re-read memory on a hit, or whose cache compared the wrong bits, would return the new frame or raise a read. It also fetches the same faulting page twice and expects two reads, so a design that cached faults would answer the second one silently. It fills one more page than there are ways and probes both the evicted page and its neighbour, which catches a wrong replacement order. Descriptor address wrap at the top of the 4 GB space, junk flag bits in the descriptor, an unaligned redirect address and a stray read-data beat while idle each check for a masking or state-tracking slip.

// File: rtl/flat_xlate.sv
module flat_xlate #(
  parameter int ID_W = 4,
  parameter int WAYS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     tbl_base,
  input  logic [31:0]     prot_addr,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_va,
  input  logic [ID_W-1:0] req_id,
  output logic            rsp_valid,
  output logic [31:0]     rsp_pa,
  output logic            rsp_fault,
  output logic            rsp_nonsec,
  output logic [ID_W-1:0] rsp_id,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  output logic            flt_valid,
  output logic [31:0]     flt_va,
  output logic [ID_W-1:0] flt_id
);
  localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int VPN_W = 20;

  logic [VPN_W-1:0] tag_q [WAYS];
  logic [VPN_W-1:0] frm_q [WAYS];
  logic [WAYS-1:0]  ns_q;
  logic [WAYS-1:0]  vld_q;
  logic [PTR_W-1:0] ptr_q;
  logic             busy_q;
  logic [31:0]      va_q;
  logic [ID_W-1:0]  id_q;

  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [VPN_W-1:0] hit_frm;
  logic             hit_ns;
  logic             accept;
  logic             desc_ok;
  logic             unused_bits;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[w] && (tag_q[w] == req_va[31:12]);
  end

  always_comb begin
    hit_frm = '0;
    hit_ns  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_frm = hit_frm | frm_q[w];
        hit_ns  = hit_ns | ns_q[w];
      end
    end
  end

  assign hit       = |hit_vec;
  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign desc_ok   = mem_rdata[1];
  assign flt_va    = va_q;
  assign flt_id    = id_q;
  assign unused_bits = ^{mem_rdata[11:4], mem_rdata[2], mem_rdata[0], prot_addr[6:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_fault  <= 1'b0;
      rsp_nonsec <= 1'b0;
      rsp_id     <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      flt_valid  <= 1'b0;
      va_q       <= '0;
      id_q       <= '0;
      vld_q      <= '0;
      ns_q       <= '0;
      ptr_q      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_req   <= 1'b0;
      flt_valid <= 1'b0;
      if (accept) begin
        va_q <= req_va;
        id_q <= req_id;
        if (hit) begin
          rsp_valid  <= 1'b1;
          rsp_pa     <= {hit_frm, req_va[11:0]};
          rsp_fault  <= 1'b0;
          rsp_nonsec <= hit_ns;
          rsp_id     <= req_id;
        end else begin
          busy_q   <= 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= tbl_base + {10'b0, req_va[31:12], 2'b00};
        end
      end else if (busy_q && mem_rvalid) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_id    <= id_q;
        if (desc_ok) begin
          rsp_pa        <= {mem_rdata[31:12], va_q[11:0]};
          rsp_fault     <= 1'b0;
          rsp_nonsec    <= mem_rdata[3];
          vld_q[ptr_q]  <= 1'b1;
          ns_q[ptr_q]   <= mem_rdata[3];
          ptr_q         <= (ptr_q == PTR_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
        end else begin
          rsp_pa     <= {prot_addr[31:7], 7'b0};
          rsp_fault  <= 1'b1;
          rsp_nonsec <= 1'b0;
          flt_valid  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q && mem_rvalid && desc_ok) begin
      tag_q[ptr_q] <= va_q[31:12];
      frm_q[ptr_q] <= mem_rdata[31:12];
    end
  end

  p_one_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_miss_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !hit) |=> (mem_req && !req_ready));
  p_hit_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit) |=> (rsp_valid && !mem_req));
  p_fault_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (rsp_valid && rsp_fault));
  p_redirect_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa[6:0] == 7'b0 && !rsp_nonsec));
  p_single_way_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_rvalid) |=> !req_ready);
endmodule

// File: tb/flat_xlate_bench.sv
module flat_xlate_bench;
  localparam int ID_W = 4;

  typedef struct packed {
    logic [31:0]     pa;
    logic            fault;
    logic            ns;
    logic [ID_W-1:0] id;
    logic [31:0]     va;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     tbl_base = 32'h8000_0000;
  logic [31:0]     prot_addr = 32'h0ABC_DEFF;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [31:0]     req_va = '0;
  logic [ID_W-1:0] req_id = '0;
  logic            rsp_valid;
  logic [31:0]     rsp_pa;
  logic            rsp_fault;
  logic            rsp_nonsec;
  logic [ID_W-1:0] rsp_id;
  logic            mem_req;
  logic [31:0]     mem_addr;
  logic            mem_rvalid = 1'b0;
  logic [31:0]     mem_rdata = '0;
  logic            flt_valid;
  logic [31:0]     flt_va;
  logic [ID_W-1:0] flt_id;

  int   n_chk = 0;
  int   n_bad = 0;
  int   lat = 2;
  logic [19:0] gen = '0;
  int   stray_req = 0;
  int   stray_done = 0;
  bit   finished = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  flat_xlate #(.ID_W(ID_W), .WAYS(4)) u_flat_xlate (.*);

  function automatic logic [31:0] desc_of(input logic [19:0] page, input logic [19:0] g);
    return {page ^ 20'h5A5A5 ^ g, 8'hF0, page[1], 1'b1, ~page[0], 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [19:0] pg;
        pg = 20'((mem_addr - tbl_base) >> 2);
        repeat (lat) @(negedge clk);
        mem_rdata  = desc_of(pg, gen);
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end else if (stray_req != stray_done) begin
        stray_done++;
        mem_rdata  = 32'hDEAD_B002;
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (sb_q.size() == 0) begin
          chk(0, "R6 unexpected response", rsp_pa, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rsp_pa == e.pa, e.fault ? "R5 redirect pa" : "R3 pa", rsp_pa, e.pa);
          chk(rsp_fault == e.fault, "R5 fault flag", 32'(rsp_fault), 32'(e.fault));
          chk(rsp_nonsec == e.ns, "R4 nonsec", 32'(rsp_nonsec), 32'(e.ns));
          chk(rsp_id == e.id, "R10 id", 32'(rsp_id), 32'(e.id));
          chk(flt_valid == e.fault, "R5 fault pulse", 32'(flt_valid), 32'(e.fault));
          if (e.fault) begin
            chk(flt_va == e.va, "R5 fault va", flt_va, e.va);
            chk(flt_id == e.id, "R5 fault id", 32'(flt_id), 32'(e.id));
          end
        end
      end else if (rst_n && flt_valid) begin
        chk(0, "R5 lone fault pulse", 32'(flt_valid), 32'h0);
      end
    end
  end

  task automatic send(input logic [31:0] va, input logic [ID_W-1:0] id,
                      input bit exp_hit, input logic [31:0] d);
    exp_t e;
    logic [31:0] ea;
    e.va = va;
    e.id = id;
    e.fault = !d[1];
    e.ns = d[1] ? d[3] : 1'b0;
    e.pa = d[1] ? {d[31:12], va[11:0]} : {prot_addr[31:7], 7'b0};
    ea = tbl_base + {10'b0, va[31:12], 2'b00};
    @(negedge clk);
    req_valid = 1'b1;
    req_va = va;
    req_id = id;
    while (!req_ready) @(negedge clk);
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      chk(rsp_valid && !mem_req, "R7 hit next cycle no read", {mem_req, rsp_valid}, 32'h1);
    end else begin
      chk(mem_req, "R2 miss read pulse", 32'(mem_req), 32'h1);
      chk(mem_addr == ea, "R2 descriptor address", mem_addr, ea);
      chk(!req_ready, "R6 busy during miss", 32'(req_ready), 32'h0);
      @(negedge clk);
      chk(!mem_req, "R2 single pulse", 32'(mem_req), 32'h0);
    end
  endtask

  task automatic drain;
    int t = 0;
    while (sb_q.size() != 0 && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(sb_q.size() == 0, "R3 response arrived", sb_q.size(), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req && !flt_valid, "R1 reset state",
        {req_ready, rsp_valid, mem_req, flt_valid}, 32'h8);
    rst_n = 1'b1;

    lat = 3;
    send(32'h0001_0ABC, 4'd3, 0, desc_of(20'h00010, 0));
    drain();
    send(32'h0001_0123, 4'd5, 1, desc_of(20'h00010, 0));
    drain();
    lat = 0;
    send(32'h0001_2FFF, 4'd6, 0, desc_of(20'h00012, 0));
    drain();

    // faulting page, twice (R5, R8)
    lat = 1;
    send(32'h0001_1040, 4'd9, 0, desc_of(20'h00011, 0));
    drain();
    send(32'h0001_1044, 4'd10, 0, desc_of(20'h00011, 0));
    drain();

    // address wrap at top of space (R2)
    tbl_base = 32'hFFFF_F000;
    send(32'h0040_0008, 4'd1, 0, desc_of(20'h00400, 0));
    drain();
    tbl_base = 32'h8000_0000;

    // table changes, cached result kept (R7)
    gen = 20'h0F0F0;
    send(32'h0001_0777, 4'd2, 1, desc_of(20'h00010, 0));
    send(32'h0001_2001, 4'd4, 1, desc_of(20'h00012, 0));
    drain();

    // stray read data while idle (R6)
    stray_req++;
    repeat (4) @(negedge clk);
    chk(!rsp_valid && req_ready, "R6 stray data ignored", {rsp_valid, req_ready}, 32'h1);

    // round-robin replacement (R9)
    send(32'h0002_0000, 4'd7, 0, desc_of(20'h00020, gen));
    drain();
    send(32'h0002_2000, 4'd8, 0, desc_of(20'h00022, gen));
    drain();
    send(32'h0001_2010, 4'd11, 1, desc_of(20'h00012, 0));
    drain();
    send(32'h0001_0010, 4'd12, 0, desc_of(20'h00010, gen));
    drain();
    send(32'h0001_2020, 4'd13, 0, desc_of(20'h00012, gen));
    drain();
    send(32'h0002_0abc, 4'd14, 1, desc_of(20'h00020, gen));
    drain();

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R6 actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule